// File: doc/BRIEF.md
# Regulator enable and setpoint selector

This block decides, for a single switching regulator channel, whether the output stage is enabled and which 8-bit voltage setpoint code is handed to it. Configuration arrives as static register bits: a software enable, a pin-control bit, a pin-select bit, a dual-level bit, a 4-bit rising-edge delay, a 4-bit falling-edge delay, and two 8-bit setpoints, one normal (high) and one low.

Two external enable pins pass through a two-flop synchroniser. The pin-select bit picks one of them. In pin on/off mode, that pin switches the output on and off. Each edge takes effect only after its programmed number of periods of an external prescaled tick. In dual-level mode the output stays enabled and the filtered pin chooses between the high and low setpoints. Under software control the pins are ignored, and the software enable acts on the next clock with no delay.

A fault input from a supervisor drops the enable at once. The enable then stays low until software clears its enable bit and sets it again. A one-clock start pulse marks every rise of the enable output.

Top module: `vreg_en_sel`

## Requirements
- R1: While sw_en_i is 0, en_o is 0 and vset_o is 0 one clock later, whatever the pins and other bits are.
- R2: With sw_en_i=1 and pin_ctrl_i=0, en_o is 1 and vset_o equals vset_hi_i one clock later, and both pins have no effect.
- R3: With pin_ctrl_i=1, pin_sel_i=0 makes pin_a_i the governing pin and pin_sel_i=1 makes pin_b_i the governing pin. The other pin has no effect.
- R4: With pin_ctrl_i=1 and dual_lvl_i=0, a low filtered pin gives en_o=0 and vset_o=0, and a high filtered pin gives en_o=1 with vset_o=vset_hi_i.
- R5: With pin_ctrl_i=1 and dual_lvl_i=1, en_o stays 1. vset_o is vset_lo_i when the filtered pin is low and vset_hi_i when it is high.
- R6: A rising edge of the governing pin reaches the filtered level after rise_dly_i periods of tick_i. With a delay of 0, en_o follows on the 4th clock edge after the pin changes: 2 synchroniser flops, 1 filter flop and 1 output flop.
- R7: A falling edge of the governing pin reaches the filtered level after fall_dly_i periods of tick_i.
- R8: If the governing pin returns to its filtered level before a pending delay expires, the pending change is cancelled. A later edge reloads the full delay.
- R9: Changes of sw_en_i take effect on en_o one clock later, with no edge delay.
- R10: start_o is high for exactly the one clock in which en_o first reads 1 after being 0.
- R11: fault_i=1 forces en_o to 0 one clock later. en_o stays 0 until sw_en_i has been 0 for at least one clock and is set again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Prescaled time-base tick, one clock wide |
| sw_en_i | input | 1 | Software enable |
| pin_ctrl_i | input | 1 | 1: pins govern the channel; 0: software only |
| pin_sel_i | input | 1 | 0: pin_a_i governs; 1: pin_b_i governs |
| dual_lvl_i | input | 1 | 1: pin selects between setpoints; 0: pin switches on/off |
| rise_dly_i | input | 4 | Rising-edge delay in tick periods |
| fall_dly_i | input | 4 | Falling-edge delay in tick periods |
| vset_hi_i | input | 8 | Normal setpoint code |
| vset_lo_i | input | 8 | Low setpoint code |
| pin_a_i | input | 1 | External enable pin A (asynchronous) |
| pin_b_i | input | 1 | External enable pin B (asynchronous) |
| fault_i | input | 1 | Supervisor fault disable |
| en_o | output | 1 | Regulator enable |
| vset_o | output | 8 | Active setpoint code, 0 while disabled |
| start_o | output | 1 | One-clock pulse on the rise of en_o |

## Verification
The assertions check on every cycle the relations that need no history beyond one clock: software-disable forcing, software-mode output and setpoint, dual-level mode keeping the enable high, immediate fault shutdown, and the start pulse matching each enable rise. The bench scenarios cover the behaviour that spans the synchroniser and the tick-timed delays. This includes the exact edge on which a zero-delay pin change appears, the window in which a delayed edge must not yet have acted, cancellation and reload of a pending delay, the fault latch surviving until a software re-enable, and the irrelevance of the unselected pin.

// File: rtl/vreg_pkg.sv
package vreg_pkg;
  typedef enum logic [1:0] {
    CTRL_SW        = 2'd0,
    CTRL_PIN_ONOFF = 2'd1,
    CTRL_PIN_LEVEL = 2'd2
  } ctrl_mode_e;
endpackage

// File: rtl/vreg_sync.sv
module vreg_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni)
          if (!rst_ni) stg_q[i] <= '0;
          else         stg_q[i] <= d_i;
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni)
          if (!rst_ni) stg_q[i] <= '0;
          else         stg_q[i] <= stg_q[i-1];
      end
    end
  endgenerate

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/vreg_edge_timer.sv
module vreg_edge_timer #(
  parameter int DLY_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             lvl_i,
  input  logic [DLY_W-1:0] rise_dly_i,
  input  logic [DLY_W-1:0] fall_dly_i,
  output logic             lvl_o
);
  logic             lvl_q, busy_q;
  logic [DLY_W-1:0] cnt_q;
  logic [DLY_W-1:0] dly;

  assign dly = lvl_i ? rise_dly_i : fall_dly_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q  <= 1'b0;
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (lvl_i == lvl_q) begin
      busy_q <= 1'b0;                    // reversal cancels pending change
    end else if (!busy_q) begin
      if (dly == '0) lvl_q <= lvl_i;
      else begin
        busy_q <= 1'b1;
        cnt_q  <= dly;
      end
    end else if (tick_i) begin
      if (cnt_q == DLY_W'(1)) begin
        lvl_q  <= lvl_i;
        busy_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q - DLY_W'(1);
      end
    end
  end

  assign lvl_o = lvl_q;
endmodule

// File: rtl/vreg_en_sel.sv
module vreg_en_sel
  import vreg_pkg::*;
#(
  parameter int VSET_W      = 8,
  parameter int DLY_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              sw_en_i,
  input  logic              pin_ctrl_i,
  input  logic              pin_sel_i,
  input  logic              dual_lvl_i,
  input  logic [DLY_W-1:0]  rise_dly_i,
  input  logic [DLY_W-1:0]  fall_dly_i,
  input  logic [VSET_W-1:0] vset_hi_i,
  input  logic [VSET_W-1:0] vset_lo_i,
  input  logic              pin_a_i,
  input  logic              pin_b_i,
  input  logic              fault_i,
  output logic              en_o,
  output logic [VSET_W-1:0] vset_o,
  output logic              start_o
);
  logic [1:0]        pins_s;
  logic              sel_lvl, pin_lvl;
  logic              fault_hold_q;
  logic              en_d;
  logic [VSET_W-1:0] vset_d;
  ctrl_mode_e        mode;

  vreg_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({pin_b_i, pin_a_i}),
    .q_o    (pins_s)
  );

  assign sel_lvl = pin_sel_i ? pins_s[1] : pins_s[0];

  vreg_edge_timer #(.DLY_W(DLY_W)) u_tmr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_i),
    .lvl_i      (sel_lvl),
    .rise_dly_i (rise_dly_i),
    .fall_dly_i (fall_dly_i),
    .lvl_o      (pin_lvl)
  );

  always_comb begin
    if (!pin_ctrl_i)     mode = CTRL_SW;
    else if (dual_lvl_i) mode = CTRL_PIN_LEVEL;
    else                 mode = CTRL_PIN_ONOFF;
  end

  // fault latch clears only while software enable is low
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       fault_hold_q <= 1'b0;
    else if (!sw_en_i) fault_hold_q <= 1'b0;
    else if (fault_i)  fault_hold_q <= 1'b1;
  end

  always_comb begin
    en_d   = 1'b0;
    vset_d = vset_hi_i;
    unique case (mode)
      CTRL_SW:        en_d = 1'b1;
      CTRL_PIN_ONOFF: en_d = pin_lvl;
      CTRL_PIN_LEVEL: begin
        en_d = 1'b1;
        if (!pin_lvl) vset_d = vset_lo_i;
      end
      default:        en_d = 1'b0;
    endcase
    en_d = en_d & sw_en_i & ~fault_hold_q & ~fault_i;
    if (!en_d) vset_d = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o    <= 1'b0;
      vset_o  <= '0;
      start_o <= 1'b0;
    end else begin
      en_o    <= en_d;
      vset_o  <= vset_d;
      start_o <= en_d & ~en_o;
    end
  end
endmodule

// File: rtl/vreg_en_sel_chk.sv
module vreg_en_sel_chk #(
  parameter int VSET_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sw_en_i,
  input logic              pin_ctrl_i,
  input logic              dual_lvl_i,
  input logic              fault_i,
  input logic              fault_hold_q,
  input logic [VSET_W-1:0] vset_hi_i,
  input logic              en_o,
  input logic [VSET_W-1:0] vset_o,
  input logic              start_o
);
  assert_sw_off_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sw_en_i |=> (!en_o && vset_o == '0));

  assert_sw_on_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_en_i && !pin_ctrl_i && !fault_i && !fault_hold_q)
      |=> (en_o && vset_o == $past(vset_hi_i)));

  assert_dual_on_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_en_i && pin_ctrl_i && dual_lvl_i && !fault_i && !fault_hold_q) |=> en_o);

  assert_start_rise_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> (en_o && !$past(en_o)));

  assert_rise_start_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(en_o) |-> start_o);

  assert_fault_off_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_i |=> !en_o);
endmodule

bind vreg_en_sel vreg_en_sel_chk #(.VSET_W(VSET_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .sw_en_i      (sw_en_i),
  .pin_ctrl_i   (pin_ctrl_i),
  .dual_lvl_i   (dual_lvl_i),
  .fault_i      (fault_i),
  .fault_hold_q (fault_hold_q),
  .vset_hi_i    (vset_hi_i),
  .en_o         (en_o),
  .vset_o       (vset_o),
  .start_o      (start_o)
);

// File: tb/tb_vreg_en_sel.sv
`timescale 1ns/1ps
module tb_vreg_en_sel;
  logic       clk = 1'b0, rst_ni = 1'b0, tick_i = 1'b0;
  logic       sw_en_i = 0, pin_ctrl_i = 0, pin_sel_i = 0, dual_lvl_i = 0;
  logic [3:0] rise_dly_i = 0, fall_dly_i = 0;
  logic [7:0] vset_hi_i = 8'h5a, vset_lo_i = 8'h21;
  logic       pin_a_i = 0, pin_b_i = 0, fault_i = 0;
  logic       en_o, start_o;
  logic [7:0] vset_o;
  int         n_chk = 0, n_fail = 0;
  int         tick_cnt = 0;
  int unsigned seed = 32'd12345;

  always #5 clk = ~clk;

  always @(posedge clk) begin
    tick_cnt <= (tick_cnt == 3) ? 0 : tick_cnt + 1;
    tick_i   <= (tick_cnt == 3);
  end

  vreg_en_sel dut (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick_i), .sw_en_i(sw_en_i),
    .pin_ctrl_i(pin_ctrl_i), .pin_sel_i(pin_sel_i), .dual_lvl_i(dual_lvl_i),
    .rise_dly_i(rise_dly_i), .fall_dly_i(fall_dly_i), .vset_hi_i(vset_hi_i),
    .vset_lo_i(vset_lo_i), .pin_a_i(pin_a_i), .pin_b_i(pin_b_i),
    .fault_i(fault_i), .en_o(en_o), .vset_o(vset_o), .start_o(start_o)
  );

  function automatic logic exp_en(logic sw, logic pc, logic ps, logic dl, logic a, logic b);
    logic p = ps ? b : a;
    if (!sw) return 1'b0;
    if (!pc || dl) return 1'b1;
    return p;
  endfunction

  function automatic logic [7:0] exp_vset(logic sw, logic pc, logic ps, logic dl,
                                          logic a, logic b, logic [7:0] hi, logic [7:0] lo);
    logic p = ps ? b : a;
    if (!exp_en(sw, pc, ps, dl, a, b)) return 8'h00;
    if (pc && dl && !p) return lo;
    return hi;
  endfunction

  task automatic edges(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    void'($urandom(seed));
    edges(3);
    chk("R1 reset en", {7'd0, en_o}, 8'd0);
    chk("R1 reset vset", vset_o, 8'd0);
    chk("R10 reset start", {7'd0, start_o}, 8'd0);
    @(negedge clk) rst_ni = 1'b1;
    edges(2);

    // software mode
    @(negedge clk); sw_en_i = 1; pin_a_i = 0; pin_b_i = 1;
    edges(1);
    chk("R9 sw enable next clock", {7'd0, en_o}, 8'd1);
    chk("R10 start pulse high", {7'd0, start_o}, 8'd1);
    chk("R2 vset hi", vset_o, 8'h5a);
    edges(1);
    chk("R10 start pulse one clock", {7'd0, start_o}, 8'd0);
    @(negedge clk); pin_a_i = 1; pin_b_i = 0;
    edges(6);
    chk("R2 pins ignored en", {7'd0, en_o}, 8'd1);
    chk("R2 pins ignored start", {7'd0, start_o}, 8'd0);
    @(negedge clk); sw_en_i = 0;
    edges(1);
    chk("R9 sw disable next clock", {7'd0, en_o}, 8'd0);
    chk("R1 vset zero", vset_o, 8'd0);

    // pin on/off via pin A with delays
    @(negedge clk); pin_a_i = 0; pin_b_i = 0; pin_ctrl_i = 1; pin_sel_i = 0;
    rise_dly_i = 3; fall_dly_i = 2; sw_en_i = 1;
    edges(12);
    chk("R4 pin low disables", {7'd0, en_o}, 8'd0);
    @(negedge clk); pin_b_i = 1;
    edges(12);
    chk("R3 unselected pin B ignored", {7'd0, en_o}, 8'd0);
    @(negedge clk); pin_a_i = 1;
    edges(11);
    chk("R6 rise not before delay", {7'd0, en_o}, 8'd0);
    edges(7);
    chk("R6 rise after delay", {7'd0, en_o}, 8'd1);
    chk("R4 vset hi when on", vset_o, 8'h5a);
    @(negedge clk); pin_a_i = 0;
    edges(7);
    chk("R7 fall not before delay", {7'd0, en_o}, 8'd1);
    edges(7);
    chk("R7 fall after delay", {7'd0, en_o}, 8'd0);

    // cancel and reload
    @(negedge clk); pin_a_i = 1;
    edges(6);
    @(negedge clk); pin_a_i = 0;
    edges(20);
    chk("R8 reversed edge cancelled", {7'd0, en_o}, 8'd0);
    @(negedge clk); pin_a_i = 1;
    edges(11);
    chk("R8 delay reloaded", {7'd0, en_o}, 8'd0);
    edges(7);
    chk("R8 later edge completes", {7'd0, en_o}, 8'd1);

    // pin B, zero delay: exact latency
    @(negedge clk); pin_a_i = 0; pin_b_i = 0; pin_sel_i = 1; rise_dly_i = 0; fall_dly_i = 0;
    edges(8);
    chk("R3 pin B selected low", {7'd0, en_o}, 8'd0);
    @(negedge clk); pin_b_i = 1;
    edges(3);
    chk("R6 zero delay edge 3", {7'd0, en_o}, 8'd0);
    edges(1);
    chk("R6 zero delay edge 4", {7'd0, en_o}, 8'd1);

    // dual-level mode
    @(negedge clk); dual_lvl_i = 1; pin_b_i = 0;
    edges(6);
    chk("R5 low pin en stays", {7'd0, en_o}, 8'd1);
    chk("R5 low pin vset lo", vset_o, 8'h21);
    @(negedge clk); pin_b_i = 1;
    edges(6);
    chk("R5 high pin vset hi", vset_o, 8'h5a);

    // fault latch
    @(negedge clk); pin_ctrl_i = 0; dual_lvl_i = 0; fault_i = 1;
    edges(1);
    chk("R11 fault drops en", {7'd0, en_o}, 8'd0);
    @(negedge clk); fault_i = 0;
    edges(6);
    chk("R11 fault held", {7'd0, en_o}, 8'd0);
    @(negedge clk); sw_en_i = 0;
    @(negedge clk); sw_en_i = 1;
    edges(1);
    chk("R11 re-enable clears fault", {7'd0, en_o}, 8'd1);

    // constrained random steady-state, zero delays
    for (int i = 0; i < 60; i++) begin
      logic sw, pc, ps, dl, a, b;
      logic [7:0] hi, lo;
      @(negedge clk);
      sw = 1'($urandom % 4 != 0); pc = 1'($urandom); ps = 1'($urandom);
      dl = 1'($urandom); a = 1'($urandom); b = 1'($urandom);
      hi = 8'($urandom); lo = 8'($urandom);
      sw_en_i = sw; pin_ctrl_i = pc; pin_sel_i = ps; dual_lvl_i = dl;
      pin_a_i = a; pin_b_i = b; vset_hi_i = hi; vset_lo_i = lo;
      rise_dly_i = 0; fall_dly_i = 0;
      edges(6);
      chk("R1 R2 R3 R4 R5 random en", {7'd0, en_o}, {7'd0, exp_en(sw, pc, ps, dl, a, b)});
      chk("R1 R2 R3 R4 R5 random vset", vset_o, exp_vset(sw, pc, ps, dl, a, b, hi, lo));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule